// File: doc/BRIEF.md
# Fall-Through Strobe-Handshake FIFO

This block is a 64-word, 4-bit first-in first-out buffer. A writer hands words over with a shift-in strobe, and a reader takes them with a shift-out strobe. Both strobes come from outside the system clock domain. The block synchronizes each strobe with two flops and then interprets it against registered state. Input-ready tells the writer that a new word can be taken. Output-ready tells the reader that an unread word is present on the data outputs.

The oldest committed word falls through to the output holding register without any request from the reader. A word becomes committed once its shift-in strobe has dropped. The last word read stays on the outputs after it is removed. An active-low output enable forces the data outputs to zero and drops a drive-enable output, which models a high-impedance bus. It leaves both flags alone.

The occupancy is the number of words held in the ring store plus the word in the holding register. It never exceeds 64.

Top module: `ft_fifo`

## Requirements
- R1: Up to 64 words are held at once, counting the word in the output holding register. Words leave in exactly the order they were captured.
- R2: When `shift_in` is high, not full, and no word has yet been taken for this high period, the word on `din` is captured. Exactly one word is captured for each high period of `shift_in`.
- R3: A captured word does not reach the outputs while its `shift_in` is still high. Once `shift_in` is low, the oldest word loads into the holding register automatically if that register is empty, and `out_ready` rises in the same update.
- R4: A falling edge of `shift_out` while an unread word is held removes that word. If another committed word is stored, it loads in that same update.
- R5: A `shift_in` high period while full captures nothing. A `shift_out` pulse while no unread word is held changes neither the flags nor `dout`.
- R6: After the last word is removed, `dout` keeps showing that word until a new word loads or reset is asserted.
- R7: `out_ready` is low while the synchronized `shift_out` is high, except for the R9 pulse. It is also low whenever no unread word is held.
- R8: `in_ready` is low while a word taken during the current `shift_in` high period is outstanding, and low while the occupancy is 64. Otherwise it is high.
- R9: If the buffer is empty and `shift_out` is held high while a word falls through, `out_ready` is high for exactly one clock. That word is then removed on the next falling edge of `shift_out`.
- R10: If the buffer is full and `shift_in` is held high, a falling edge of `shift_out` makes `in_ready` high for exactly one clock. The word on `din` is then captured without a new `shift_in` edge.
- R11: While `rst_n` is low, `in_ready` is 1, `out_ready` is 0, `dout` is 0 and all stored words are discarded. If `shift_in` is high when `rst_n` rises, that word is captured, and `in_ready` stays low until `shift_in` falls.
- R12: While `oe_n` is high, `dout` is 0 and `dout_oe` is 0, and neither flag changes. While `oe_n` is low, `dout_oe` is 1 and `dout` shows the holding register.
- R13: A level change on `shift_in` or `shift_out` reaches the flags on the third rising clock edge after it. For example, `in_ready` is still 1 after two edges following a rise of `shift_in`, and it is 0 after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset, asynchronous assert |
| shift_in | input | 1 | Write strobe from the writer, asynchronous |
| shift_out | input | 1 | Read strobe from the reader, asynchronous |
| din | input | 4 | Write data, held stable while `shift_in` is high |
| oe_n | input | 1 | Active-low output enable |
| in_ready | output | 1 | Ready to accept a word |
| out_ready | output | 1 | Unread word present on `dout` |
| dout | output | 4 | Output data, 0 when disabled |
| dout_oe | output | 1 | Drive enable for `dout` (1 = driven) |

## Verification
Two pairs of functions can fall in the same clock. In the first pair, a removal and an automatic capture meet: the buffer is filled to 64 with `shift_in` held high on a pending word, and `shift_out` is then pulsed. The bench counts the clocks in which `in_ready` is high and expects exactly one. It then expects the held word to come out last, after the 63 older ones. In the second pair, a fall-through load meets a high `shift_out`: a word is written into the empty buffer while `shift_out` stays high. The bench expects exactly one clock of `out_ready` and expects the word to be gone after `shift_out` falls.

// File: rtl/ftf_pkg.sv
package ftf_pkg;

    // strobe slots inside the shared synchronizer
    localparam int unsigned STB_WR  = 0;
    localparam int unsigned STB_RD  = 1;
    localparam int unsigned NUM_STB = 2;

    // one synchronized strobe as seen by the control logic
    typedef struct packed {
        logic lvl;   // synchronized level
        logic fall;  // high for one clock after a high-to-low change
    } strobe_t;

endpackage

// File: rtl/ftf_strobe_sync.sv
module ftf_strobe_sync #(
    parameter int unsigned N      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] fall_o
);

    localparam int unsigned LAST = STAGES - 1;

    for (genvar g = 0; g < N; g++) begin : g_stb
        // bits [STAGES-1:0] form the synchronizer chain, bit STAGES holds the previous level
        logic [STAGES:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-1:0], pin[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign lvl_o[g]  = chain_q[LAST];
        assign fall_o[g] = chain_q[STAGES] & ~chain_q[LAST];
    end

endmodule

// File: rtl/ftf_ring.sv
module ftf_ring #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic                       rd_en,
    output logic [WIDTH-1:0]           rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } ring_t;

    ring_t s_d, s_q;
    logic [WIDTH-1:0] mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (wr_en) s_d.wp = bump(s_q.wp);
        if (rd_en) s_d.rp = bump(s_q.rp);
        case ({wr_en, rd_en})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[s_q.wp] <= wr_data;
    end

    assign rd_data = mem_q[s_q.rp];
    assign count   = s_q.cnt;

    // the controller must never push into a full store or pop an empty one
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (s_q.cnt < CNT_W'(DEPTH)));
    assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (s_q.cnt != '0));

endmodule

// File: rtl/ftf_ctrl.sv
module ftf_ctrl
    import ftf_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  strobe_t                    wr_stb,
    input  strobe_t                    rd_stb,
    input  logic [WIDTH-1:0]           din,
    input  logic [$clog2(DEPTH+1)-1:0] ring_cnt,
    input  logic [WIDTH-1:0]           ring_rd,
    output logic                       ring_push,
    output logic                       ring_pop,
    output logic                       in_ready,
    output logic                       out_ready,
    output logic [WIDTH-1:0]           word
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic             taken;     // a word was taken during this shift-in high period
        logic             pend;      // youngest stored word still waits for shift-in to drop
        logic             hold_full; // holding register carries an unread word
        logic             ir;
        logic             ordy;
        logic [WIDTH-1:0] word;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic             cap, pend_live, avail, take_out, load;
    logic [CNT_W-1:0] occ, ring_nxt, occ_nxt;

    always_comb begin
        occ       = ring_cnt + CNT_W'(s_q.hold_full);
        cap       = wr_stb.lvl & ~s_q.taken & (occ < FULL);
        pend_live = s_q.pend & ~wr_stb.fall;
        avail     = ring_cnt > CNT_W'(pend_live);
        take_out  = rd_stb.fall & s_q.hold_full;
        load      = (~s_q.hold_full | take_out) & avail;
        ring_nxt  = ring_cnt + CNT_W'(cap) - CNT_W'(load);

        s_d           = s_q;
        s_d.taken     = wr_stb.lvl & (s_q.taken | cap);
        s_d.pend      = pend_live | cap;
        s_d.hold_full = load | (s_q.hold_full & ~take_out);
        if (load) s_d.word = ring_rd;
        occ_nxt       = ring_nxt + CNT_W'(s_d.hold_full);
        s_d.ir        = (occ_nxt < FULL) & ~s_d.taken;
        s_d.ordy      = s_d.hold_full & (~rd_stb.lvl | load);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.ir   <= 1'b1;
        end else begin
            s_q      <= s_d;
        end
    end

    assign ring_push = cap;
    assign ring_pop  = load;
    assign in_ready  = s_q.ir;
    assign out_ready = s_q.ordy;
    assign word      = s_q.word;

    // output-ready only advertises a word that is actually held
    assert_ordy_has_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ordy |-> s_q.hold_full);
    // input-ready never shows while the buffer is full
    assert_ir_not_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ir |-> (occ < FULL));
    // input-ready stays low while the word of this strobe is outstanding
    assert_ir_low_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pend |-> !s_q.ir);
    // an empty holding register keeps the last word unchanged
    assert_last_word_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.hold_full && $past(!s_q.hold_full)) |-> $stable(s_q.word));
    // with shift-out high, output-ready lasts at most one clock
    assert_ordy_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.ordy) && $past(rd_stb.lvl)) |-> !s_q.ordy);
    // occupancy never passes the capacity
    assert_occ_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL);

endmodule

// File: rtl/ft_fifo.sv
module ft_fifo
    import ftf_pkg::*;
#(
    parameter int unsigned WIDTH       = 4,
    parameter int unsigned DEPTH       = 64,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_in,
    input  logic             shift_out,
    input  logic [WIDTH-1:0] din,
    input  logic             oe_n,
    output logic             in_ready,
    output logic             out_ready,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [NUM_STB-1:0] stb_pins, stb_lvl, stb_fall;
    strobe_t            wr_stb, rd_stb;
    logic               push, pop;
    logic [WIDTH-1:0]   rd_word, hold_word;
    logic [CNT_W-1:0]   cnt;

    always_comb begin
        stb_pins         = '0;
        stb_pins[STB_WR] = shift_in;
        stb_pins[STB_RD] = shift_out;
    end

    ftf_strobe_sync #(.N(NUM_STB), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (stb_pins),
        .lvl_o  (stb_lvl),
        .fall_o (stb_fall)
    );

    assign wr_stb = '{lvl: stb_lvl[STB_WR], fall: stb_fall[STB_WR]};
    assign rd_stb = '{lvl: stb_lvl[STB_RD], fall: stb_fall[STB_RD]};

    ftf_ring #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push),
        .wr_data (din),
        .rd_en   (pop),
        .rd_data (rd_word),
        .count   (cnt)
    );

    ftf_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .din       (din),
        .ring_cnt  (cnt),
        .ring_rd   (rd_word),
        .ring_push (push),
        .ring_pop  (pop),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .word      (hold_word)
    );

    assign dout    = oe_n ? '0 : hold_word;
    assign dout_oe = ~oe_n;

endmodule

// File: tb/tb_ft_fifo.sv
module tb_ft_fifo;

    localparam int W = 4;
    localparam int D = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_in = 1'b0;
    logic         shift_out = 1'b0;
    logic [W-1:0] din = '0;
    logic         oe_n = 1'b0;
    logic         in_ready, out_ready, dout_oe;
    logic [W-1:0] dout;

    int checks = 0;
    int failures = 0;
    bit mon_ir = 0;
    bit mon_or = 0;
    int ir_hi = 0;
    int or_hi = 0;

    always #2.5 clk = ~clk;

    ft_fifo dut (
        .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .shift_out(shift_out),
        .din(din), .oe_n(oe_n), .in_ready(in_ready), .out_ready(out_ready),
        .dout(dout), .dout_oe(dout_oe)
    );

    always @(negedge clk) begin
        if (mon_ir && in_ready)  ir_hi++;
        if (mon_or && out_ready) or_hi++;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [W-1:0] pat(input int i);
        return W'((i * 7 + 3) % 16);
    endfunction

    task automatic push(input logic [W-1:0] w);
        din = w; shift_in = 1'b1; cyc(4);
        shift_in = 1'b0; cyc(4);
    endtask

    task automatic pull(input logic [W-1:0] exp, input string req);
        chk(req, "out_ready before read", int'(out_ready), 1);
        chk(req, "dout before read", int'(dout), int'(exp));
        shift_out = 1'b1; cyc(4);
        chk("R7", "out_ready while shift_out high", int'(out_ready), 0);
        shift_out = 1'b0; cyc(4);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; cyc(3);
        chk("R11", "in_ready in reset", int'(in_ready), 1);
        chk("R11", "out_ready in reset", int'(out_ready), 0);
        chk("R11", "dout in reset", int'(dout), 0);
        chk("R12", "dout_oe enabled", int'(dout_oe), 1);
        rst_n = 1'b1; cyc(3);
    endtask

    task automatic t_timing;
        din = 4'h3; shift_in = 1'b1;
        cyc(2);
        chk("R13", "in_ready after two edges", int'(in_ready), 1);
        cyc(1);
        chk("R13", "in_ready after third edge", int'(in_ready), 0);
        cyc(3);
        chk("R3", "no fall-through while shift_in high", int'(out_ready), 0);
        chk("R8", "in_ready low while shift_in high", int'(in_ready), 0);
        shift_in = 1'b0; cyc(4);
        chk("R3", "dout after fall-through", int'(dout), 3);
        chk("R8", "in_ready back high", int'(in_ready), 1);
        pull(4'h3, "R2");
        chk("R7", "out_ready when empty", int'(out_ready), 0);
        chk("R6", "last word kept", int'(dout), 3);
    endtask

    task automatic t_order;
        for (int i = 0; i < 5; i++) push(pat(i + 10));
        for (int i = 0; i < 5; i++) pull(pat(i + 10), "R1");
        chk("R4", "empty after reads", int'(out_ready), 0);
    endtask

    task automatic t_empty_read;
        shift_out = 1'b1; cyc(4); shift_out = 1'b0; cyc(4);
        chk("R5", "out_ready after read while empty", int'(out_ready), 0);
        chk("R5", "dout after read while empty", int'(dout), int'(pat(14)));
        chk("R5", "in_ready after read while empty", int'(in_ready), 1);
        push(4'h6);
        pull(4'h6, "R5");
    endtask

    task automatic t_full;
        for (int i = 0; i < D; i++) push(pat(i));
        chk("R8", "in_ready when full", int'(in_ready), 0);
        push(4'hF);
        chk("R5", "in_ready after write while full", int'(in_ready), 0);
        din = 4'h5; shift_in = 1'b1; cyc(4);
        chk("R10", "in_ready full with shift_in high", int'(in_ready), 0);
        chk("R10", "oldest word on dout", int'(dout), int'(pat(0)));
        ir_hi = 0; mon_ir = 1;
        shift_out = 1'b1; cyc(4); shift_out = 1'b0; cyc(6);
        mon_ir = 0;
        chk("R10", "in_ready pulse width", ir_hi, 1);
        chk("R10", "in_ready after auto capture", int'(in_ready), 0);
        shift_in = 1'b0; cyc(4);
        chk("R8", "in_ready full again", int'(in_ready), 0);
        for (int i = 1; i < D; i++) pull(pat(i), "R1");
        pull(4'h5, "R10");
        chk("R1", "empty after draining", int'(out_ready), 0);
        chk("R8", "in_ready after draining", int'(in_ready), 1);
    endtask

    task automatic t_or_pulse;
        shift_out = 1'b1; cyc(4);
        or_hi = 0; mon_or = 1;
        push(4'hC);
        mon_or = 0;
        chk("R9", "out_ready pulse width", or_hi, 1);
        chk("R9", "out_ready with shift_out held", int'(out_ready), 0);
        chk("R3", "word fell through", int'(dout), 12);
        shift_out = 1'b0; cyc(6);
        chk("R9", "word removed on fall", int'(out_ready), 0);
        chk("R6", "removed word still shown", int'(dout), 12);
        push(4'h7);
        pull(4'h7, "R9");
    endtask

    task automatic t_oe;
        push(4'hA);
        oe_n = 1'b1; cyc(2);
        chk("R12", "dout disabled", int'(dout), 0);
        chk("R12", "dout_oe disabled", int'(dout_oe), 0);
        chk("R12", "out_ready unaffected", int'(out_ready), 1);
        chk("R12", "in_ready unaffected", int'(in_ready), 1);
        oe_n = 1'b0; cyc(2);
        chk("R12", "dout re-enabled", int'(dout), 10);
        pull(4'hA, "R12");
    endtask

    task automatic t_reset_si;
        push(4'h2);
        rst_n = 1'b0; din = 4'h9; shift_in = 1'b1; cyc(3);
        chk("R11", "in_ready during reset", int'(in_ready), 1);
        chk("R11", "out_ready during reset", int'(out_ready), 0);
        chk("R11", "dout cleared", int'(dout), 0);
        rst_n = 1'b1; cyc(5);
        chk("R11", "in_ready held low after release", int'(in_ready), 0);
        chk("R11", "no output while shift_in high", int'(out_ready), 0);
        shift_in = 1'b0; cyc(5);
        chk("R11", "captured word shown", int'(dout), 9);
        chk("R11", "in_ready after shift_in low", int'(in_ready), 1);
        pull(4'h9, "R11");
        chk("R11", "old contents discarded", int'(out_ready), 0);
    endtask

    initial begin
        t_reset;
        t_timing;
        t_order;
        t_empty_read;
        t_full;
        t_or_pulse;
        t_oe;
        t_reset_si;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule